// File: doc/BRIEF.md
# Bus Read-Data Stability Monitor

This block is a passive checker placed next to a memory-mapped bus slave. It observes a copy of the slave's handshake signals (cycle, strobe, write enable, select, acknowledge) and the slave's read data output. The rule it enforces is one the bus protocol itself leaves open: the slave's read data must stay unchanged except just after reset or in a cycle that completes an acknowledged read. A slave that drives fresh values onto its data output at any other time can pass information to an observer on the bus without breaking any stated protocol rule. The monitor makes that behaviour visible.

Every clock the monitor keeps the previous read data value and compares it with the current one. A change in a cycle that is not a qualified, acknowledged read counts as a violation. Violations set a flag that stays set until reset and advance a count that saturates. The first violation also records the offending data word and the index of the cycle in which it appeared, counted from reset release. The first cycle after reset release is never checked, so that the slave can load its reset value.

Top module: `rdata_guard`

## Requirements
- R1: While `rstN` is low at a clock edge, `violFlag`, `violCount`, `capData` and `capCycle` are all zero after that edge.
- R2: In the first cycle after reset release (cycle index 0), a change of `busRdata` relative to its value during reset is not a violation.
- R3: A change of `busRdata` in a cycle where `busCyc`, `busStb`, `busSel` and `busAck` are 1 and `busWe` is 0 is not a violation.
- R4: A change of `busRdata` in a cycle with `busWe` = 1 is a violation, even when `busAck` is 1.
- R5: A change of `busRdata` while `busCyc` or `busStb` is 0 is a violation.
- R6: A change of `busRdata` with `busAck` = 1 but `busSel` = 0 is a violation: an acknowledge without all read qualifiers permits nothing.
- R7: A cycle where `busRdata` equals its value in the previous cycle is never a violation, whatever the handshake signals.
- R8: Once set, `violFlag` stays 1 until the next reset.
- R9: `violCount` rises by exactly one for each violating cycle and stays at 2^CNT_W-1 once it reaches it.
- R10: On the first violation after reset, `capData` takes the new `busRdata` value and `capCycle` takes that cycle's index (0 for the first cycle after reset release, counting up by one per cycle and saturating); later violations leave both unchanged.
- R11: All outputs are registered: the effect of a violating cycle appears after the clock edge that ends that cycle, not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busCyc | input | 1 | Observed bus cycle-valid signal |
| busStb | input | 1 | Observed strobe |
| busWe | input | 1 | Observed write enable (1 = write) |
| busSel | input | 1 | Observed slave select |
| busAck | input | 1 | Observed slave acknowledge |
| busRdata | input | DATA_W | Observed slave read data output |
| violFlag | output | 1 | Sticky violation flag |
| violCount | output | CNT_W | Saturating violation count |
| capData | output | DATA_W | Read data value of the first violation |
| capCycle | output | CYC_W | Cycle index of the first violation |

## Verification
Every result is due one clock edge after the cycle whose inputs cause it: the bench drives inputs on the falling edge, advances its own reference model for that cycle, and compares all four outputs a quarter period after the next rising edge. For the registered-output requirement the bench also samples just after driving a violating cycle, where the outputs must still hold their earlier values. Random handshake and data patterns from a fixed seed are mixed with directed cases for the reset-release exemption, each missing read qualifier, capture ordering and count saturation.

// File: rtl/rdata_guard_pkg.sv
package rdata_guard_pkg;

  // Strobes from the rule evaluator to the datapath
  typedef struct packed {
    logic capture;  // record current data word and cycle index
    logic tick;     // advance the cycle index
  } monStrobe_t;

endpackage

// File: rtl/rdata_guard_dp.sv
module rdata_guard_dp
  import rdata_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busRdata,
  input  monStrobe_t        strobes,
  output logic              dataChanged,
  output logic [DATA_W-1:0] capData,
  output logic [CYC_W-1:0]  capCycle
);

  localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

  logic [DATA_W-1:0] prevData;
  logic [CYC_W-1:0]  cycIdx;

  // Previous-value register feeding the change comparator
  always_ff @(posedge clk) begin
    if (!rstN) prevData <= '0;
    else       prevData <= busRdata;
  end

  assign dataChanged = (busRdata != prevData);

  // Cycle index since reset release, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                              cycIdx <= '0;
    else if (strobes.tick && cycIdx != CYC_MAX) cycIdx <= cycIdx + 1'b1;
  end

  // Capture registers for the first offending word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capData  <= '0;
      capCycle <= '0;
    end else if (strobes.capture) begin
      capData  <= busRdata;
      capCycle <= cycIdx;
    end
  end

  // R10
  cap_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capData != '0 && !strobes.capture) |=> $stable(capData));

  // R1
  cap_reset_chk: assert property (@(posedge clk)
    (!rstN) |=> (capData == '0 && capCycle == '0));

endmodule

// File: rtl/rdata_guard_ctrl.sv
module rdata_guard_ctrl
  import rdata_guard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busCyc,
  input  logic             busStb,
  input  logic             busWe,
  input  logic             busSel,
  input  logic             busAck,
  input  logic             dataChanged,
  output monStrobe_t       strobes,
  output logic             violFlag,
  output logic [CNT_W-1:0] violCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic armed;
  logic readGrant;
  logic violNow;

  // Checking starts one cycle after reset release
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // Only a fully qualified, acknowledged read may move the data
  assign readGrant = busCyc & busStb & busSel & ~busWe & busAck;
  assign violNow   = armed & dataChanged & ~readGrant;

  assign strobes.capture = violNow & ~violFlag;
  assign strobes.tick    = 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlag  <= 1'b0;
      violCount <= '0;
    end else if (violNow) begin
      violFlag <= 1'b1;
      if (violCount != CNT_MAX) violCount <= violCount + 1'b1;
    end
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |=> violFlag);

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violCount == CNT_MAX) |=> (violCount == CNT_MAX));

  // R2
  exempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed) |=> $stable(violCount));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violCount != CNT_MAX) |=> (violCount - $past(violCount) <= 1));

endmodule

// File: rtl/rdata_guard.sv
module rdata_guard
  import rdata_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic              busSel,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  output logic              violFlag,
  output logic [CNT_W-1:0]  violCount,
  output logic [DATA_W-1:0] capData,
  output logic [CYC_W-1:0]  capCycle
);

  monStrobe_t strobes;
  logic       dataChanged;

  rdata_guard_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busCyc      (busCyc),
    .busStb      (busStb),
    .busWe       (busWe),
    .busSel      (busSel),
    .busAck      (busAck),
    .dataChanged (dataChanged),
    .strobes     (strobes),
    .violFlag    (violFlag),
    .violCount   (violCount)
  );

  rdata_guard_dp #(.DATA_W(DATA_W), .CYC_W(CYC_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busRdata    (busRdata),
    .strobes     (strobes),
    .dataChanged (dataChanged),
    .capData     (capData),
    .capCycle    (capCycle)
  );

  // R3
  grant_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCyc && busStb && busSel && !busWe && busAck) |=> $stable(violCount));

  // R7
  hold_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata == $past(busRdata)) |=> $stable(violCount));

  // R4
  write_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busRdata != $past(busRdata) && $past(rstN) && $past(rstN, 2)) |=> violFlag);

endmodule

// File: tb/test_rdata_guard.sv
`timescale 1ns/1ps
module test_rdata_guard;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int CYC_W  = 16;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CYC_W-1:0] YMAX = {CYC_W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCyc = 0, busStb = 0, busWe = 0, busSel = 0, busAck = 0;
  logic [DATA_W-1:0] busRdata = '0;
  logic              violFlag;
  logic [CNT_W-1:0]  violCount;
  logic [DATA_W-1:0] capData;
  logic [CYC_W-1:0]  capCycle;

  always #10 clk = ~clk;  // 50 MHz

  rdata_guard #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) i_rdata_guard (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busSel(busSel), .busAck(busAck), .busRdata(busRdata),
    .violFlag(violFlag), .violCount(violCount), .capData(capData), .capCycle(capCycle)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Reference model state
  bit                mArmed = 0;
  logic [DATA_W-1:0] mPrev  = '0;
  logic [CYC_W-1:0]  mCyc   = '0;
  bit                mFlag  = 0;
  logic [CNT_W-1:0]  mCnt   = '0;
  logic [DATA_W-1:0] mCapD  = '0;
  logic [CYC_W-1:0]  mCapC  = '0;

  function automatic bit isGrant(bit c, bit s, bit w, bit l, bit a);
    return c && s && l && !w && a;
  endfunction

  function automatic void modelStep(bit r, bit c, bit s, bit w, bit l, bit a,
                                    logic [DATA_W-1:0] d);
    if (!r) begin
      mArmed = 0; mPrev = '0; mCyc = '0; mFlag = 0; mCnt = '0; mCapD = '0; mCapC = '0;
    end else begin
      if (mArmed && d != mPrev && !isGrant(c, s, w, l, a)) begin
        if (!mFlag) begin mCapD = d; mCapC = mCyc; end
        mFlag = 1;
        if (mCnt != CMAX) mCnt = mCnt + 1'b1;
      end
      mPrev = d;
      mArmed = 1;
      if (mCyc != YMAX) mCyc = mCyc + 1'b1;
    end
  endfunction

  task automatic compare(string tag);
    nChecks++;
    if (violFlag !== mFlag || violCount !== mCnt || capData !== mCapD || capCycle !== mCapC) begin
      nFails++;
      $display("FAIL %s: got flag=%0b cnt=%0d cap=%h cyc=%0d, expected flag=%0b cnt=%0d cap=%h cyc=%0d",
               tag, violFlag, violCount, capData, capCycle, mFlag, mCnt, mCapD, mCapC);
    end
  endtask

  // One cycle: drive at falling edge, sample after the next rising edge
  task automatic step(bit r, bit c, bit s, bit w, bit l, bit a,
                      logic [DATA_W-1:0] d, string tag, bit chk);
    @(negedge clk);
    rstN = r; busCyc = c; busStb = s; busWe = w; busSel = l; busAck = a; busRdata = d;
    modelStep(r, c, s, w, l, a, d);
    @(posedge clk);
    #5;
    if (chk) compare(tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [DATA_W-1:0] d;
    void'($urandom(32'd4711));

    // R1: reset state
    step(0, 0, 0, 0, 0, 0, 32'h0, "R1 reset", 1);
    step(0, 1, 1, 1, 1, 1, 32'h1234, "R1 reset with activity", 1);
    // R2: first cycle after release exempt
    step(1, 0, 0, 0, 0, 0, 32'hA5A5_0001, "R2 exempt first cycle", 1);
    // R7: hold under various handshakes
    step(1, 0, 0, 0, 0, 0, 32'hA5A5_0001, "R7 hold idle", 1);
    step(1, 1, 1, 1, 1, 1, 32'hA5A5_0001, "R7 hold write ack", 1);
    // R3: qualified acknowledged read
    step(1, 1, 1, 0, 1, 1, 32'h0000_BEEF, "R3 granted read", 1);
    // R6: ack without select; R10 first capture; R11 latency
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = 0; busSel = 0; busAck = 1; busRdata = 32'h0000_1111;
    #2;
    compare("R11 before edge");
    modelStep(1, 1, 1, 0, 0, 1, 32'h0000_1111);
    @(posedge clk); #5;
    compare("R6 ack without select");
    compare("R10 first capture");
    // R4: write cycle change, capture held
    step(1, 1, 1, 1, 1, 1, 32'h0000_2222, "R4 write change", 1);
    // R5: idle changes
    step(1, 0, 1, 0, 1, 1, 32'h0000_3333, "R5 no cycle", 1);
    step(1, 1, 0, 0, 1, 1, 32'h0000_4444, "R5 no strobe", 1);
    // R8: clean cycles keep flag
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 1, 1, 32'h0000_5000 + i, "R8 sticky", 1);
    // R9: saturation
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 0, 32'h0001_0000 + i, "R9 counting", 0);
    compare("R9 saturated");
    step(1, 1, 0, 1, 0, 0, 32'hFFFF_0000, "R9 stays saturated", 1);
    // R1: reset clears, R10 fresh capture after reset
    step(0, 0, 0, 0, 0, 0, 32'h0, "R1 clear", 1);
    step(1, 0, 0, 0, 0, 0, 32'h0000_0077, "R2 exempt again", 1);
    step(1, 1, 1, 1, 1, 0, 32'h0000_0078, "R10 fresh capture", 1);

    // Random mix
    d = 32'h0;
    for (int i = 0; i < 3000; i++) begin
      bit r, c, s, w, l, a;
      r = ($urandom % 100) != 0;
      c = ($urandom % 4) != 0;
      s = ($urandom % 4) != 0;
      w = ($urandom % 3) == 0;
      l = ($urandom % 4) != 0;
      a = ($urandom % 2) != 0;
      if ($urandom % 3 == 0) d = {$urandom} % 8;
      step(r, c, s, w, l, a, d, "R3 R4 R5 R6 R7 random", 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule